// File: doc/BRIEF.md
# Inter-Processor Interrupt Mailbox Bank

This block is a memory-mapped register bank that lets processor cores interrupt each other and exchange short messages. Each core owns one register slot. A slot holds a status word, an enable word, a write-one-to-set port, a write-one-to-clear port and a small mailbox of 64-bit words. A core sends a doorbell to another core by writing bits into that core's set port. It passes a payload through the mailbox. The receiving core acknowledges through its clear port. Each slot drives one registered interrupt line.

The bus side is a simple request/response interface that handles one access per cycle, 4 or 8 bytes wide. Each request is decoded to a node and a core. Within the slot it is decoded to a register kind: `K_STAT`, `K_EN`, `K_SET`, `K_CLR`, `K_MBX` or `K_NONE`. A small response state machine answers every request one cycle later. It has three states:
- `RSP_IDLE`: no response is being returned.
- `RSP_OK`: a normal response is being returned.
- `RSP_FAULT`: an error response is being returned.

The state machine moves on each edge as follows:
- to `RSP_OK` on a legal request;
- to `RSP_FAULT` on a misaligned request;
- to `RSP_IDLE` when no request is present.

These transitions apply from any state.

Top module: `ipi_mailbox_bank`

## Requirements
- R1: After reset, every status word, enable word and mailbox word is zero, every `irq_o` bit is low and `rsp_valid` is low.
- R2: The target slot index is {`req_addr[45:44]` (node), `req_addr[9:8]` (core)}, that is core + 4*node, for 16 slots in all. The register offset is `req_addr[7:0]`. Address bits [43:10] are ignored. An access changes or reads only the slot it targets.
- R3: Offset 0x04 is the enable word. It is plain read/write and has no effect on the interrupt. Reads of offset 0x00 (status) and 0x04 (enable) return the stored 32-bit value in `rsp_rdata[31:0]`, with the upper half zero.
- R4: A write to offset 0x08 ORs `req_wdata[31:0]` into the slot's status. From the next cycle the slot's `irq_o` bit is high, whatever the enable word holds and even when the written data is zero.
- R5: A write to offset 0x0C clears the status bits that are one in `req_wdata[31:0]`. The slot's `irq_o` bit goes low only when the status after the clear is zero; otherwise it keeps its value.
- R6: Writes to offset 0x00 leave the status unchanged. Reads of offsets 0x08 and 0x0C return zero.
- R7: Offsets 0x20 to 0x3F hold four 64-bit mailbox words; word n sits at 0x20 + 8n. An 8-byte access reads or writes the whole word. A 4-byte access at offset bit 2 = 0 uses bits [31:0] of the word, and at offset bit 2 = 1 it uses bits [63:32]. Write data comes from `req_wdata[31:0]`, read data is returned in `rsp_rdata[31:0]`, and the other half of the word is preserved.
- R8: An access is misaligned when `req_wide`=1 and offset[2:0] is not 0, or when `req_wide`=0 and offset[1:0] is not 0. Such an access returns `rsp_err`=1 with `rsp_rdata`=0 and changes no state.
- R9: Aligned accesses to undecoded offsets (0x10 to 0x1F, 0x40 to 0xFF) return `rsp_rdata`=0 with `rsp_err`=0, and writes to them change nothing.
- R10: Each request gets `rsp_valid` and its response in the following cycle only. Back-to-back requests take effect in bus order, one per cycle. `irq_o` changes on the same edge that applies the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| req_addr | input | 46 | Byte address of the access |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Misaligned-access error response |
| rsp_rdata | output | 64 | Read data |
| irq_o | output | 16 | One interrupt line per slot |

## Verification
On every cycle, the assertions check these properties:
- the interrupt rule: a set write raises the line, a line rises only after a set write, and a line falls only when the status is empty;
- outside a clear write, status bits only accumulate;
- a misaligned request leaves the interrupt lines still and gets an error response carrying zero data;
- an idle cycle produces no response.

Other behaviours can only be shown by the bench's scenarios, which compare every response with an arithmetic model. These are:
- which slot a given address reaches;
- the exact read values of every offset at both widths;
- half-word placement in the mailbox;
- the ignored address bits;
- that enable has no effect;
- bus-order handling of a set followed at once by a clear.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    // Register offsets within one slot (low byte of the address)
    localparam logic [7:0] OFF_STAT = 8'h00;
    localparam logic [7:0] OFF_EN   = 8'h04;
    localparam logic [7:0] OFF_SET  = 8'h08;
    localparam logic [7:0] OFF_CLR  = 8'h0C;
    localparam logic [7:0] OFF_MBX  = 8'h20;

    typedef enum logic [2:0] {
        K_NONE,
        K_STAT,
        K_EN,
        K_SET,
        K_CLR,
        K_MBX
    } acc_kind_t;

    typedef struct packed {
        acc_kind_t kind;
        logic      hi;    // upper half of a mailbox word for 4-byte accesses
        logic      wide;  // 8-byte access
    } acc_t;

    typedef enum logic [1:0] {
        RSP_IDLE,
        RSP_OK,
        RSP_FAULT
    } rsp_state_t;

endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
    import ipi_pkg::*;
#(
    parameter int ADDR_W    = 46,
    parameter int CORE_LSB  = 8,
    parameter int CORE_BITS = 2,
    parameter int NODE_LSB  = 44,
    parameter int NODE_BITS = 2,
    parameter int MBX_WORDS = 4,
    localparam int IDX_W     = CORE_BITS + NODE_BITS,
    localparam int MBX_IDX_W = (MBX_WORDS > 1) ? $clog2(MBX_WORDS) : 1
) (
    input  logic                 req_valid,
    input  logic                 req_wide,
    input  logic [ADDR_W-1:0]    req_addr,
    output acc_t                 acc,
    output logic                 misaligned,
    output logic [IDX_W-1:0]     target,
    output logic [MBX_IDX_W-1:0] mbx_word
);

    localparam int OFF_W   = CORE_LSB;
    localparam int MBX_END = int'(OFF_MBX) + 8 * MBX_WORDS;

    logic [OFF_W-1:0]  off;
    logic [OFF_W-1:0]  mbx_rel;
    logic [OFF_W-1:0]  rel_unused;
    logic [ADDR_W-1:0] addr_unused;

    assign off         = req_addr[OFF_W-1:0];
    assign mbx_rel     = off - OFF_W'(OFF_MBX);
    assign rel_unused  = mbx_rel;
    assign addr_unused = req_addr;

    // Slot index: node field above core field, i.e. core + 2**CORE_BITS * node
    assign target = {req_addr[NODE_LSB +: NODE_BITS], req_addr[CORE_LSB +: CORE_BITS]};

    always_comb begin
        if (req_wide) begin
            misaligned = req_valid && (off[2:0] != 3'b000);
        end else begin
            misaligned = req_valid && (off[1:0] != 2'b00);
        end
    end

    always_comb begin
        acc.wide = req_wide;
        acc.hi   = mbx_rel[2];
        mbx_word = mbx_rel[3 +: MBX_IDX_W];
        if (off == OFF_W'(OFF_STAT)) begin
            acc.kind = K_STAT;
        end else if (off == OFF_W'(OFF_EN)) begin
            acc.kind = K_EN;
        end else if (off == OFF_W'(OFF_SET)) begin
            acc.kind = K_SET;
        end else if (off == OFF_W'(OFF_CLR)) begin
            acc.kind = K_CLR;
        end else if ((int'(off) >= int'(OFF_MBX)) && (int'(off) < MBX_END)) begin
            acc.kind = K_MBX;
        end else begin
            acc.kind = K_NONE;
        end
    end

endmodule

// File: rtl/ipi_core_slot.sv
module ipi_core_slot
    import ipi_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int STAT_W    = 32,
    parameter int MBX_WORDS = 4,
    localparam int HALF_W    = DATA_W / 2,
    localparam int MBX_IDX_W = (MBX_WORDS > 1) ? $clog2(MBX_WORDS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic                 req_write,
    input  acc_t                 acc,
    input  logic [MBX_IDX_W-1:0] mbx_word,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic [DATA_W-1:0]    rd_value,
    output logic                 irq
);

    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] en_q;
    logic [DATA_W-1:0] mbx_q [MBX_WORDS];
    logic [STAT_W-1:0] cleared;
    logic              wr_hit;
    logic              set_hit;
    logic              clr_hit;

    assign wr_hit  = sel && req_write;
    assign set_hit = wr_hit && (acc.kind == K_SET);
    assign clr_hit = wr_hit && (acc.kind == K_CLR);
    assign cleared = stat_q & ~req_wdata[STAT_W-1:0];

    // Status word and interrupt line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            irq    <= 1'b0;
        end else if (set_hit) begin
            stat_q <= stat_q | req_wdata[STAT_W-1:0];
            irq    <= 1'b1;
        end else if (clr_hit) begin
            stat_q <= cleared;
            if (cleared == '0) begin
                irq <= 1'b0;
            end
        end
    end

    // Enable word: stored only, never gates the interrupt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_hit && (acc.kind == K_EN)) begin
            en_q <= req_wdata[STAT_W-1:0];
        end
    end

    // Mailbox words
    for (genvar w = 0; w < MBX_WORDS; w++) begin : g_mbx
        logic word_hit;
        assign word_hit = wr_hit && (acc.kind == K_MBX) && (mbx_word == MBX_IDX_W'(w));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mbx_q[w] <= '0;
            end else if (word_hit) begin
                if (acc.wide) begin
                    mbx_q[w] <= req_wdata;
                end else if (acc.hi) begin
                    mbx_q[w][DATA_W-1:HALF_W] <= req_wdata[HALF_W-1:0];
                end else begin
                    mbx_q[w][HALF_W-1:0] <= req_wdata[HALF_W-1:0];
                end
            end
        end
    end

    // Read value for the decoded register
    always_comb begin
        rd_value = '0;
        unique case (acc.kind)
            K_STAT: rd_value = DATA_W'(stat_q);
            K_EN:   rd_value = DATA_W'(en_q);
            K_MBX: begin
                if (acc.wide) begin
                    rd_value = mbx_q[mbx_word];
                end else if (acc.hi) begin
                    rd_value = {{HALF_W{1'b0}}, mbx_q[mbx_word][DATA_W-1:HALF_W]};
                end else begin
                    rd_value = {{HALF_W{1'b0}}, mbx_q[mbx_word][HALF_W-1:0]};
                end
            end
            default: rd_value = '0;
        endcase
    end

    AST_SET_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        set_hit |=> irq) else $error("set write did not raise irq"); // R4

    AST_IRQ_RISE_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(set_hit)) else $error("irq rose without set write"); // R4

    AST_IRQ_FALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> (stat_q == '0)) else $error("irq fell with status pending"); // R5

    AST_STATUS_ONLY_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_hit |=> ((stat_q & $past(stat_q)) == $past(stat_q))) else $error("status bit lost without clear"); // R6

endmodule

// File: rtl/ipi_rsp_fsm.sv
module ipi_rsp_fsm
    import ipi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic misaligned,
    output logic rsp_valid,
    output logic rsp_err
);

    rsp_state_t state_q;
    rsp_state_t state_d;

    always_comb begin
        if (!req_valid) begin
            state_d = RSP_IDLE;
        end else if (misaligned) begin
            state_d = RSP_FAULT;
        end else begin
            state_d = RSP_OK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        unique case (state_q)
            RSP_IDLE:  begin rsp_valid = 1'b0; rsp_err = 1'b0; end
            RSP_OK:    begin rsp_valid = 1'b1; rsp_err = 1'b0; end
            RSP_FAULT: begin rsp_valid = 1'b1; rsp_err = 1'b1; end
            default:   begin rsp_valid = 1'b0; rsp_err = 1'b0; end
        endcase
    end

    AST_IDLE_NO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid) else $error("response without request"); // R10

    AST_FAULT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        misaligned |=> (rsp_valid && rsp_err)) else $error("misaligned access not flagged"); // R8

endmodule

// File: rtl/ipi_mailbox_bank.sv
module ipi_mailbox_bank
    import ipi_pkg::*;
#(
    parameter int ADDR_W    = 46,
    parameter int DATA_W    = 64,
    parameter int STAT_W    = 32,
    parameter int CORE_LSB  = 8,
    parameter int CORE_BITS = 2,
    parameter int NODE_LSB  = 44,
    parameter int NODE_BITS = 2,
    parameter int MBX_WORDS = 4,
    localparam int IDX_W     = CORE_BITS + NODE_BITS,
    localparam int NUM_CORES = 1 << IDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 req_wide,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic [NUM_CORES-1:0] irq_o
);

    localparam int MBX_IDX_W = (MBX_WORDS > 1) ? $clog2(MBX_WORDS) : 1;

    acc_t                 acc;
    logic                 misaligned;
    logic [IDX_W-1:0]     target;
    logic [MBX_IDX_W-1:0] mbx_word;
    logic                 legal;
    logic [DATA_W-1:0]    rd_vals [NUM_CORES];

    assign legal = req_valid && !misaligned;

    ipi_decode #(
        .ADDR_W   (ADDR_W),
        .CORE_LSB (CORE_LSB),
        .CORE_BITS(CORE_BITS),
        .NODE_LSB (NODE_LSB),
        .NODE_BITS(NODE_BITS),
        .MBX_WORDS(MBX_WORDS)
    ) u_decode (
        .req_valid (req_valid),
        .req_wide  (req_wide),
        .req_addr  (req_addr),
        .acc       (acc),
        .misaligned(misaligned),
        .target    (target),
        .mbx_word  (mbx_word)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_slot
        logic sel;
        assign sel = legal && (target == IDX_W'(c));

        ipi_core_slot #(
            .DATA_W   (DATA_W),
            .STAT_W   (STAT_W),
            .MBX_WORDS(MBX_WORDS)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (sel),
            .req_write(req_write),
            .acc      (acc),
            .mbx_word (mbx_word),
            .req_wdata(req_wdata),
            .rd_value (rd_vals[c]),
            .irq      (irq_o[c])
        );
    end

    ipi_rsp_fsm u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .misaligned(misaligned),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
        end else if (legal && !req_write) begin
            rsp_rdata <= rd_vals[target];
        end else begin
            rsp_rdata <= '0;
        end
    end

    AST_FAULT_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == '0)) else $error("error response carried data"); // R8

    AST_FAULT_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        misaligned |=> $stable(irq_o)) else $error("misaligned access moved irq"); // R8

    AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_rdata == '0)) else $error("write returned data"); // R10

endmodule

// File: tb/ipi_mailbox_bank_tb.sv
`timescale 1ns/100ps
module ipi_mailbox_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_wide = 1'b0;
    logic [45:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [63:0] rsp_rdata;
    logic [15:0] irq_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] m_stat [16];
    logic [31:0] m_en   [16];
    logic [63:0] m_mbx  [16][4];
    logic [15:0] m_irq;

    always #2.5 clk = ~clk;

    ipi_mailbox_bank dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_wide (req_wide),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .rsp_valid(rsp_valid),
        .rsp_err  (rsp_err),
        .rsp_rdata(rsp_rdata),
        .irq_o    (irq_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [45:0] mk_addr(input int id, input int off);
        logic [45:0] a;
        a = '0;
        a[45:44] = id[3:2];
        a[9:8]   = id[1:0];
        a[7:0]   = off[7:0];
        a[27:10] = 18'(id * 18'h1F3 + 18'h155);  // ignored bits (R2)
        return a;
    endfunction

    // Reference model step: returns expected error and read data, updates model state
    task automatic model_step(input logic w, input logic wide, input int id, input int off,
                              input logic [63:0] wd, output logic e_err, output logic [63:0] e_rd);
        int wi;
        e_rd  = '0;
        e_err = wide ? (off[2:0] != 0) : (off[1:0] != 0);
        if (!e_err) begin
            wi = (off - 32) / 8;
            if (!w) begin
                if (off == 0) e_rd = {32'h0, m_stat[id]};
                else if (off == 4) e_rd = {32'h0, m_en[id]};
                else if (off >= 32 && off < 64) begin
                    if (wide) e_rd = m_mbx[id][wi];
                    else if (off[2]) e_rd = {32'h0, m_mbx[id][wi][63:32]};
                    else e_rd = {32'h0, m_mbx[id][wi][31:0]};
                end
            end else begin
                if (off == 4) m_en[id] = wd[31:0];
                else if (off == 8) begin
                    m_stat[id] = m_stat[id] | wd[31:0];
                    m_irq[id]  = 1'b1;
                end else if (off == 12) begin
                    m_stat[id] = m_stat[id] & ~wd[31:0];
                    if (m_stat[id] == 32'h0) m_irq[id] = 1'b0;
                end else if (off >= 32 && off < 64) begin
                    if (wide) m_mbx[id][wi] = wd;
                    else if (off[2]) m_mbx[id][wi][63:32] = wd[31:0];
                    else m_mbx[id][wi][31:0] = wd[31:0];
                end
            end
        end
    endtask

    task automatic acc(input string tag, input logic w, input logic wide, input int id,
                       input int off, input logic [63:0] wd);
        logic        e_err;
        logic [63:0] e_rd;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = w;
        req_wide  = wide;
        req_addr  = mk_addr(id, off);
        req_wdata = wd;
        model_step(w, wide, id, off, wd, e_err, e_rd);
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, 64'(rsp_valid), 64'd1);
        check({tag, " err"},   64'(rsp_err),   64'(e_err));
        check({tag, " rdata"}, rsp_rdata,      e_rd);
        check({tag, " irq"},   64'(irq_o),     64'(m_irq));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_stat[i] = '0;
            m_en[i]   = '0;
            for (int j = 0; j < 4; j++) m_mbx[i][j] = '0;
        end
        m_irq = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at the ports
        check("R1 irq after reset", 64'(irq_o), 64'h0);
        check("R1 no response after reset", 64'(rsp_valid), 64'h0);
        for (int id = 0; id < 16; id++) begin
            acc("R1 status zero", 1'b0, 1'b1, id, 0, '0);
            acc("R1 mailbox zero", 1'b0, 1'b1, id, 56, '0);
        end

        // R3: enable plain read/write, no interrupt effect; R2: per-slot isolation
        for (int id = 0; id < 16; id++)
            acc("R3 enable write", 1'b1, 1'b0, id, 4, {32'hDEAD_0000, 32'(id * 32'h0101_0101 + 32'h11)});
        for (int id = 0; id < 16; id++)
            acc("R3 enable read", 1'b0, 1'b0, id, 4, '0);

        // R4: set raises irq regardless of enable and data; R2 slot targeting
        for (int id = 0; id < 16; id++)
            acc("R4 set write", 1'b1, 1'b1, id, 8, {32'hFFFF_FFFF, 32'(1 << (id % 32)) | 32'h8000_0000});
        acc("R4 set zero data", 1'b1, 1'b0, 3, 8, 64'h0);
        for (int id = 0; id < 16; id++)
            acc("R2 status per slot", 1'b0, 1'b0, id, 0, '0);

        // R5: partial clear keeps irq, full clear drops it
        for (int id = 0; id < 16; id++) begin
            acc("R5 partial clear", 1'b1, 1'b0, id, 12, 64'h0000_0000_8000_0000);
            acc("R5 full clear", 1'b1, 1'b0, id, 12, 64'h0000_0000_FFFF_FFFF);
        end
        // zero-data set then zero-data clear drops irq on empty status
        acc("R4 set empty", 1'b1, 1'b0, 9, 8, 64'h0);
        acc("R5 clear empty", 1'b1, 1'b0, 9, 12, 64'h0);

        // R6: status write ignored, set/clear read zero
        acc("R6 prime status", 1'b1, 1'b0, 6, 8, 64'h0000_0000_00F0_000F);
        acc("R6 status write", 1'b1, 1'b0, 6, 0, 64'h0000_0000_FFFF_FFFF);
        acc("R6 status write wide", 1'b1, 1'b1, 6, 0, 64'h0);
        acc("R6 status readback", 1'b0, 1'b0, 6, 0, '0);
        acc("R6 set reads zero", 1'b0, 1'b0, 6, 8, '0);
        acc("R6 clear reads zero", 1'b0, 1'b0, 6, 12, '0);
        acc("R6 set reads zero wide", 1'b0, 1'b1, 6, 8, '0);

        // R7: mailbox words and halves
        for (int id = 0; id < 16; id++)
            for (int w = 0; w < 4; w++)
                acc("R7 mailbox wide write", 1'b1, 1'b1, id, 32 + 8 * w,
                    {32'(id * 32'h1357 + w), 32'(w * 32'h0F0F_0F0F + id)});
        acc("R7 mailbox hi write", 1'b1, 1'b0, 2, 44, 64'hBAD0_BAD0_CAFE_F00D);
        acc("R7 mailbox lo write", 1'b1, 1'b0, 2, 48, 64'h1111_1111_2468_ACE0);

        // R2/R3/R7/R9: exhaustive aligned/misaligned read sweep of every offset, both widths
        for (int id = 0; id < 16; id++)
            for (int off = 0; off < 256; off++) begin
                acc("R9 read sweep narrow", 1'b0, 1'b0, id, off, '0);
                if (off % 2 == 0) acc("R7 read sweep wide", 1'b0, 1'b1, id, off, '0);
            end

        // R8: misaligned writes change nothing
        for (int off = 0; off < 64; off++)
            if (off[1:0] != 0) acc("R8 misaligned narrow write", 1'b1, 1'b0, 11, off, 64'hFFFF_FFFF_FFFF_FFFF);
        for (int off = 0; off < 64; off++)
            if (off[2:0] != 0) acc("R8 misaligned wide write", 1'b1, 1'b1, 11, off, 64'hFFFF_FFFF_FFFF_FFFF);

        // R9: undecoded aligned writes change nothing
        for (int off = 16; off < 256; off += 4)
            if (off < 32 || off >= 64) acc("R9 undecoded write", 1'b1, 1'b0, 11, off, 64'hFFFF_FFFF_FFFF_FFFF);
        for (int off = 0; off < 64; off += 4)
            acc("R9 state after writes", 1'b0, 1'b0, 11, off, '0);

        // R10: back-to-back set then clear on the same slot, then read
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_wide = 1'b0;
        req_addr = mk_addr(5, 8); req_wdata = 64'h1;
        @(negedge clk);
        check("R10 first rsp valid", 64'(rsp_valid), 64'd1);
        check("R10 irq after set", 64'(irq_o[5]), 64'd1);
        req_addr = mk_addr(5, 12); req_wdata = 64'h1;
        @(negedge clk);
        check("R10 second rsp valid", 64'(rsp_valid), 64'd1);
        check("R10 irq after clear", 64'(irq_o[5]), 64'd0);
        req_write = 1'b0; req_addr = mk_addr(5, 0);
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 read status", rsp_rdata, 64'h0);
        @(negedge clk);
        check("R10 idle no rsp", 64'(rsp_valid), 64'd0);
        check("R10 irq vector", 64'(irq_o), 64'(m_irq));

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule